// File: doc/BRIEF.md
# SPI-Mode SD Read Block Streamer

This block produces the card side of the data phase of an SPI-mode SD read. A command sequencer starts it with the index of the read command. After that, every byte exchange on the serial link returns the next byte of a framed data block. The block begins with a start token and continues with data bytes pulled one at a time from an abstract byte source. It ends with a 16-bit CRC that is computed on the fly while the data goes out. For a multi-block read the streamer inserts one idle gap byte and starts the next block without help from the sequencer. Single-block reads and short blocks return control to the command state.

While any read state is active, every byte that the host sends is compared with the stop-transmission command byte. A match aborts the stream at once. The card then sends at least one idle byte, and control returns to the command state. A one-cycle done pulse tells the sequencer that control has come back. Byte exchanges are one-cycle strobes. The byte sent back on an exchange is presented in the same cycle as the strobe, and the state advances on the clock edge that ends that cycle.

Top module: `sdrd_stream`

## Requirements
- R1: In the command state every exchange returns 0xFF, and `src_pull` stays low.
- R2: A `start` pulse in the command state latches `cmd_idx`. The next exchange returns the start token 0xFE.
- R3: Each exchange in the data phase returns `src_data` and raises `src_pull` in that same cycle.
- R4: The data phase of a block ends after 512 bytes, or after a byte that was presented with `src_rdy` low (`src_rdy` high means more bytes follow the one presented).
- R5: The CRC uses polynomial 0x1021 and is fed data bits most significant bit first. It is cleared to zero on each start token. It goes out high byte first, then low byte, on the two exchanges after the data.
- R6: After the CRC of a full 512-byte block whose latched command index is not 17, one 0xFF gap exchange follows and then a new start token. In every other case control returns to the command state.
- R7: An exchange that carries the byte 0x4C during the gap, token, data or CRC phase returns 0xFF and pulls nothing. The next exchange returns 0xFF, after which the block is in the command state.
- R8: `done` is high for exactly one cycle, the cycle after the exchange that returns control to the command state.
- R9: A `start` pulse while streaming is ignored.
- R10: A cycle without `xfer_valid` changes no state and leaves `src_pull` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin streaming (accepted in command state only) |
| cmd_idx | input | 6 | Read command index latched on start |
| xfer_valid | input | 1 | One byte exchange takes place this cycle |
| rx_byte | input | 8 | Byte received from the host on this exchange |
| tx_byte | output | 8 | Byte returned to the host on this exchange |
| src_data | input | 8 | Byte currently presented by the source |
| src_rdy | input | 1 | More source bytes follow the one presented |
| src_pull | output | 1 | Presented source byte consumed this cycle |
| done | output | 1 | Control returned to command state (one-cycle pulse) |

## Verification
The hardest situations to reach are the stop command arriving in the one-exchange states: the inter-block gap, the token, and each CRC byte. The gap appears only after 515 exchanges of a full block in a multi-block read. The stimulus reaches it by running full 512-byte blocks and placing 0x4C at an exchange index computed from the framing. The token and CRC states are reached with very short source lengths. A behavioural per-exchange model in the bench follows every case. The CRC is also checked against the well-known check value of the nine ASCII digits, 0x31C3.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_GAP,
    ST_TOKEN,
    ST_DATA,
    ST_CRC_HI,
    ST_CRC_LO,
    ST_HOLD
  } sdrd_state_t;

  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
  localparam logic [7:0] TOKEN_BYTE = 8'hFE;
  localparam logic [7:0] STOP_BYTE  = 8'h4C;
endpackage

// File: rtl/sdrd_crc16.sv
module sdrd_crc16 #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_d, step;

  always_comb begin
    step = crc_q;
    for (int i = 7; i >= 0; i--) begin
      if (step[15] ^ din[i]) step = {step[14:0], 1'b0} ^ POLY;
      else                   step = {step[14:0], 1'b0};
    end
    if (clr)     crc_d = '0;
    else if (en) crc_d = step;
    else         crc_d = crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R5: the CRC register holds when neither cleared nor fed
  p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc_q));
endmodule

// File: rtl/sdrd_byte_cnt.sv
module sdrd_byte_cnt #(
  parameter int BLK_BYTES = 512,
  localparam int CNT_W = $clog2(BLK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             last,
  output logic             full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == CNT_W'(BLK_BYTES - 1));
  assign full = (cnt_q == CNT_W'(BLK_BYTES));

  // R4: a block never carries more than BLK_BYTES data bytes
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BLK_BYTES));
endmodule

// File: rtl/sdrd_ctrl.sv
module sdrd_ctrl
  import sdrd_pkg::*;
#(
  parameter int CMD_W      = 6,
  parameter int SINGLE_CMD = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd_idx,
  input  logic             xfer_valid,
  input  logic [7:0]       rx_byte,
  input  logic             src_rdy,
  input  logic             cnt_last,
  input  logic             cnt_full,
  output sdrd_state_t      state,
  output logic             abort,
  output logic             blk_clr,
  output logic             data_step,
  output logic             done
);
  sdrd_state_t      state_q, state_d;
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_load, done_q, done_d, in_read;

  assign in_read   = (state_q == ST_GAP) || (state_q == ST_TOKEN) || (state_q == ST_DATA) ||
                     (state_q == ST_CRC_HI) || (state_q == ST_CRC_LO);
  assign abort     = xfer_valid && in_read && (rx_byte == STOP_BYTE);
  assign blk_clr   = xfer_valid && !abort && (state_q == ST_TOKEN);
  assign data_step = xfer_valid && !abort && (state_q == ST_DATA);
  assign cmd_load  = start && (state_q == ST_CMD);

  always_comb begin
    state_d = state_q;
    if (cmd_load) begin
      state_d = ST_TOKEN;
    end else if (abort) begin
      state_d = ST_HOLD;
    end else if (xfer_valid) begin
      unique case (state_q)
        ST_GAP:    state_d = ST_TOKEN;
        ST_TOKEN:  state_d = ST_DATA;
        ST_DATA:   state_d = (cnt_last || !src_rdy) ? ST_CRC_HI : ST_DATA;
        ST_CRC_HI: state_d = ST_CRC_LO;
        ST_CRC_LO: state_d = (cnt_full && (cmd_q != CMD_W'(SINGLE_CMD))) ? ST_GAP : ST_CMD;
        ST_HOLD:   state_d = ST_CMD;
        default:   state_d = state_q;
      endcase
    end
    done_d = (state_q != ST_CMD) && (state_d == ST_CMD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_q <= '0;
    else if (cmd_load) cmd_q <= cmd_idx;
  end

  assign state = state_q;
  assign done  = done_q;

  // R2: a start in command state leads to the token state
  p_start_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && start) |=> (state_q == ST_TOKEN));
  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10: no exchange and no accepted start leaves the state alone
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_valid && !(start && state_q == ST_CMD)) |=> $stable(state_q));
  // R7: a stop byte in a read state leads to the hold state
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && rx_byte == STOP_BYTE && state_q inside {ST_GAP, ST_TOKEN, ST_DATA, ST_CRC_HI, ST_CRC_LO})
    |=> (state_q == ST_HOLD));
endmodule

// File: rtl/sdrd_stream.sv
module sdrd_stream
  import sdrd_pkg::*;
#(
  parameter int          BLK_BYTES  = 512,
  parameter int          CMD_W      = 6,
  parameter int          SINGLE_CMD = 17,
  parameter logic [15:0] CRC_POLY   = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] cmd_idx,
  input  logic             xfer_valid,
  input  logic [7:0]       rx_byte,
  output logic [7:0]       tx_byte,
  input  logic [7:0]       src_data,
  input  logic             src_rdy,
  output logic             src_pull,
  output logic             done
);
  localparam int CNT_W = $clog2(BLK_BYTES + 1);

  sdrd_state_t      state;
  logic             abort, blk_clr, data_step, cnt_last, cnt_full;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      crc;

  sdrd_ctrl #(.CMD_W(CMD_W), .SINGLE_CMD(SINGLE_CMD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .xfer_valid(xfer_valid), .rx_byte(rx_byte), .src_rdy(src_rdy),
    .cnt_last(cnt_last), .cnt_full(cnt_full), .state(state),
    .abort(abort), .blk_clr(blk_clr), .data_step(data_step), .done(done)
  );

  sdrd_byte_cnt #(.BLK_BYTES(BLK_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(blk_clr), .inc(data_step),
    .cnt(cnt), .last(cnt_last), .full(cnt_full)
  );

  sdrd_crc16 #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(blk_clr), .en(data_step),
    .din(src_data), .crc(crc)
  );

  always_comb begin
    tx_byte = IDLE_BYTE;
    if (!abort) begin
      unique case (state)
        ST_TOKEN:  tx_byte = TOKEN_BYTE;
        ST_DATA:   tx_byte = src_data;
        ST_CRC_HI: tx_byte = crc[15:8];
        ST_CRC_LO: tx_byte = crc[7:0];
        default:   tx_byte = IDLE_BYTE;
      endcase
    end
  end

  assign src_pull = data_step;

  // R10: the source is only consumed on an exchange
  p_pull_on_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    src_pull |-> xfer_valid);
  // R8: done only follows an exchange
  p_done_after_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer_valid));
  // R3: the counter moves only with a pull
  p_cnt_moves_with_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_pull && !blk_clr) |=> $stable(cnt));
endmodule

// File: tb/sdrd_stream_tb.sv
module sdrd_stream_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [5:0] cmd_idx;
  logic       xfer_valid;
  logic [7:0] rx_byte;
  logic [7:0] tx_byte;
  logic [7:0] src_data;
  logic       src_rdy;
  logic       src_pull;
  logic       done;

  always #4 clk = ~clk;

  logic [7:0] src_mem [0:2047];
  int src_len, src_ptr;
  bit pull_pending;
  assign src_data = src_mem[src_ptr];
  assign src_rdy  = (src_ptr + 1 < src_len);

  sdrd_stream dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .xfer_valid(xfer_valid), .rx_byte(rx_byte), .tx_byte(tx_byte),
    .src_data(src_data), .src_rdy(src_rdy), .src_pull(src_pull), .done(done)
  );

  int checks = 0, failures = 0;
  // model: 0 cmd, 1 gap, 2 token, 3 data, 4 crc hi, 5 crc lo, 6 hold
  int m_state = 0, m_cmd = 0, m_cnt = 0;
  logic [15:0] m_crc = 0;
  bit exp_done = 0;
  logic [7:0] last_tx;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R1";
      1: return "R6";
      2: return "R2";
      3: return "R3";
      4, 5: return "R5";
      default: return "R7";
    endcase
  endfunction

  // one clock cycle; xv selects an exchange
  task automatic cyc(bit xv, logic [7:0] rx, bit st, int cmd, string tag_ovr);
    int nxt;
    int ex_tx;
    bit ex_pull;
    string tag;
    @(negedge clk);
    if (pull_pending) src_ptr++;
    pull_pending = 0;
    xfer_valid = xv; rx_byte = rx; start = st; cmd_idx = 6'(cmd);
    #2;
    check("R8", "done", done, exp_done);
    nxt = m_state; ex_tx = 8'hFF; ex_pull = 0;
    tag = (tag_ovr != "") ? tag_ovr : tag_of(m_state);
    if (m_state == 0 && st) begin
      nxt = 2; m_cmd = cmd;
    end else if (xv && m_state >= 1 && m_state <= 5 && rx == 8'h4C) begin
      nxt = 6; tag = "R7";
    end else if (xv) begin
      case (m_state)
        1: nxt = 2;
        2: begin ex_tx = 8'hFE; m_cnt = 0; m_crc = 0; nxt = 3; end
        3: begin
          ex_tx = src_data; ex_pull = 1; m_crc = crc_upd(m_crc, src_data); m_cnt++;
          if (m_cnt == 512 || !src_rdy) nxt = 4;
        end
        4: begin ex_tx = m_crc[15:8]; nxt = 5; end
        5: begin ex_tx = m_crc[7:0]; nxt = (m_cnt == 512 && m_cmd != 17) ? 1 : 0; end
        6: nxt = 0;
        default: nxt = 0;
      endcase
    end
    if (xv) check(tag, "tx", tx_byte, ex_tx);
    check(xv ? tag : "R10", "pull", src_pull, ex_pull);
    last_tx = tx_byte;
    pull_pending = src_pull;
    exp_done = (m_state != 0 && nxt == 0);
    m_state = nxt;
    @(posedge clk);
  endtask

  task automatic fill(int len, int seed);
    for (int i = 0; i < 2048; i++) src_mem[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
    src_len = len; src_ptr = 0;
  endtask

  task automatic begin_read(int cmd);
    cyc(0, 8'hFF, 1, cmd, "R2");
  endtask

  task automatic xchg_n(int n);
    for (int i = 0; i < n; i++) cyc(1, 8'hFF, 0, 0, "");
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; cmd_idx = 0; xfer_valid = 0; rx_byte = 8'hFF;
    pull_pending = 0;
    fill(600, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2;
    check("R1", "reset done", done, 0);
    check("R1", "reset pull", src_pull, 0);
    check("R1", "reset tx", tx_byte, 8'hFF);
    // R1 idle exchanges with assorted bytes, including the stop byte
    cyc(1, 8'h4C, 0, 0, "R1");
    cyc(1, 8'h12, 0, 0, "R1");
    xchg_n(2);

    // single block read: full block then command state
    fill(600, 1);
    begin_read(17);
    xchg_n(515);
    check("R4", "pulled bytes full block", src_ptr + (pull_pending ? 1 : 0), 512);
    xchg_n(2);

    // short block with known CRC check value 0x31C3
    fill(9, 0);
    for (int i = 0; i < 9; i++) src_mem[i] = 8'h31 + 8'(i);
    begin_read(18);
    xchg_n(10);
    cyc(1, 8'hFF, 0, 0, "R5");
    check("R5", "crc hi known", last_tx, 8'h31);
    cyc(1, 8'hFF, 0, 0, "R5");
    check("R5", "crc lo known", last_tx, 8'hC3);
    check("R4", "pulled bytes short block", src_ptr + (pull_pending ? 1 : 0), 9);
    xchg_n(1);

    // multi-block read with idle cycles, ignored start, stop in data
    fill(1200, 2);
    begin_read(18);
    for (int i = 0; i < 600; i++) cyc((i % 3) != 0, 8'hFF, 0, 0, "");
    cyc(0, 8'hFF, 1, 17, "R9");
    cyc(1, 8'hFF, 1, 17, "R9");
    xchg_n(700);
    cyc(1, 8'h4C, 0, 0, "R7");
    cyc(1, 8'hFF, 0, 0, "R7");
    xchg_n(2);

    // stop during the gap
    fill(2000, 3);
    begin_read(25);
    xchg_n(515);
    cyc(1, 8'h4C, 0, 0, "R7");
    xchg_n(3);

    // stop on the token exchange
    fill(50, 4);
    begin_read(18);
    cyc(1, 8'h4C, 0, 0, "R7");
    xchg_n(2);

    // stop on the crc high byte
    fill(3, 5);
    begin_read(18);
    xchg_n(4);
    cyc(1, 8'h4C, 0, 0, "R7");
    xchg_n(2);

    // stop on the crc low byte
    fill(3, 6);
    begin_read(18);
    xchg_n(5);
    cyc(1, 8'h4C, 0, 0, "R7");
    xchg_n(2);

    // non-17 single block of 1 byte returns to command state
    fill(1, 7);
    begin_read(18);
    xchg_n(6);
    cyc(0, 8'hFF, 0, 0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule